// File: doc/BRIEF.md
# Vote-Based 8b/10b Symbol Boundary Finder

This block takes recovered 8b/10b line data one bit at a time and finds where the 10-bit symbol boundaries lie. It treats each of the ten bit positions as a candidate boundary, all at the same time. A candidate gains a vote each time a complete K28.5 comma ends on it. The aligner commits to a boundary only once one candidate has collected enough votes and every other candidate has none. After that it emits whole 10-bit symbols, a comma marker and the chosen phase.

Only the full ten-bit K28.5 code counts as a vote. Partial comma fragments and the other comma-bearing control codes are ignored. This guards against a known trap: an end-of-packet code followed by a comma forms long runs of equal bits, and one bit error there can make a comma-like pattern appear at the wrong boundary. The vote threshold is small by default, because links that scramble their idle traffic send few commas. Once locked, a run of commas at some other boundary, with no comma at the locked boundary in between, drops the lock and restarts the vote.

Top module: `comma_vote_align`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and in the cycle after it is released, `locked`, `sym_valid` and `comma_det` are 0 and `phase` is 0. Reset also clears all vote and mismatch counters and the bit history.
- R2: Valid bits are numbered from 0 starting after reset. The phase of a bit is its number mod 10. A comma hit occurs when the last ten valid bits, oldest first, equal 0011111010 or its complement 1100000101. The hit's phase is the phase of the newest bit.
- R3: No other ten-bit pattern counts as a hit. This includes 0011111001, 0011111000, a K29.7 code (1011101000) followed by a K28.5 with one bit flipped, and any bare seven-bit comma fragment. Such patterns never cause lock.
- R4: While unlocked, each hit adds one vote to its phase. When a phase reaches VOTE_TH votes (default 2) and every other phase has zero votes, the block locks. At the clock edge that samples the final comma bit, it sets `locked`, sets `phase` to that phase, clears all votes, and emits that comma as the first symbol.
- R5: If a phase reaches VOTE_TH while any other phase holds a vote, all votes are cleared and the block stays unlocked.
- R6: While locked, `sym_valid` is high for one cycle after each valid bit whose phase equals `phase`. `sym_out` then holds the last ten valid bits, with the oldest bit in bit 9.
- R7: `comma_det` is high exactly when `sym_valid` is high and the emitted symbol is a K28.5 of either polarity.
- R8: While locked, a hit at any other phase adds one to a mismatch count, and a hit at the locked phase clears it. When the count reaches MISS_TH (default 3), the block clears `locked`, clears the count and clears all votes.
- R9: A cycle with `in_valid` low does not shift the history, advance the bit count or change any counter, and `sym_valid` is 0 in the following cycle.
- R10: `phase` does not change while `locked` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_bit` carries a line bit this cycle |
| in_bit | input | 1 | Serial line bit, earliest bit first |
| sym_out | output | 10 | Aligned symbol, oldest bit in bit 9 |
| sym_valid | output | 1 | One-cycle strobe for `sym_out` |
| comma_det | output | 1 | Emitted symbol is a K28.5 |
| locked | output | 1 | Symbol boundary is committed |
| phase | output | 4 | Committed bit phase, 0 to 9 |

## Verification
If a vote counter is corrupted, the block locks too early, too late or at the wrong phase. The error shows in `locked` and `phase` at the edge that samples the deciding comma. A wrong bit-phase count or history register shows within ten valid bits, as a `sym_valid` strobe in the wrong cycle or a `sym_out` word that disagrees with the bits sent. A wrong mismatch count shows as lock being dropped one comma too early or too late. The bench runs a bit-exact reference model that is checked every cycle, so each of these faults is caught in the first cycle it appears at the ports.

// File: rtl/cva_pkg.sv
package cva_pkg;
  localparam int SYM_W = 10;
  localparam int PH_W  = $clog2(SYM_W);
  localparam logic [SYM_W-1:0] K285_RDN = 10'b0011111010;
  localparam logic [SYM_W-1:0] K285_RDP = ~K285_RDN;
endpackage

// File: rtl/cva_match.sv
module cva_match
  import cva_pkg::*;
(
  input  logic [SYM_W-1:0] window,
  output logic             is_comma
);
  // only the complete ten-bit code in either disparity counts
  always_comb is_comma = (window == K285_RDN) || (window == K285_RDP);
endmodule

// File: rtl/cva_phase_ctr.sv
module cva_phase_ctr #(
  parameter int MODULUS = 10,
  localparam int W = $clog2(MODULUS)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] ph
);
  always_ff @(posedge clk) begin
    if (rst)                            ph <= '0;
    else if (adv && ph == W'(MODULUS-1)) ph <= '0;
    else if (adv)                       ph <= ph + 1'b1;
  end
endmodule

// File: rtl/cva_vote_bank.sv
module cva_vote_bank #(
  parameter int NPH = 10,
  parameter int VTH = 2,
  localparam int PW = $clog2(NPH),
  localparam int CW = $clog2(VTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          hit,
  input  logic [PW-1:0] hit_ph,
  output logic          win,
  output logic          contest
);
  logic [CW-1:0]  cnt [NPH];
  logic [NPH-1:0] nonzero;
  logic [NPH-1:0] sel;
  logic [NPH-1:0] reach;
  logic           others;

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    assign sel[g]     = hit && (hit_ph == PW'(g));
    assign nonzero[g] = (cnt[g] != '0);
    assign reach[g]   = sel[g] && (cnt[g] == CW'(VTH - 1));
    always_ff @(posedge clk) begin
      if (rst || clr || win || contest) cnt[g] <= '0;
      else if (sel[g])                  cnt[g] <= cnt[g] + 1'b1;
    end
  end

  assign others  = |(nonzero & ~sel);
  assign win     = (|reach) && !others;
  assign contest = (|reach) && others;
endmodule

// File: rtl/comma_vote_align.sv
module comma_vote_align
  import cva_pkg::*;
#(
  parameter int VOTE_TH = 2,
  parameter int MISS_TH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic [SYM_W-1:0] sym_out,
  output logic             sym_valid,
  output logic             comma_det,
  output logic             locked,
  output logic [PH_W-1:0]  phase
);
  localparam int MW = $clog2(MISS_TH + 1);

  logic [SYM_W-1:0] hist;
  logic [SYM_W-1:0] window;
  logic [PH_W-1:0]  cur_ph;
  logic [MW-1:0]    miss;
  logic             hit, vwin, vcontest;
  logic             on_ph, emit, miss_hit, drop, keep_hit;

  assign window = {hist[SYM_W-2:0], in_bit};

  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (in_valid) hist <= window;
  end

  cva_phase_ctr #(.MODULUS(SYM_W)) u_ph (
    .clk(clk), .rst(rst), .adv(in_valid), .ph(cur_ph)
  );

  cva_match u_match (.window(window), .is_comma(hit));

  cva_vote_bank #(.NPH(SYM_W), .VTH(VOTE_TH)) u_votes (
    .clk(clk), .rst(rst), .clr(drop),
    .hit(in_valid && hit && !locked), .hit_ph(cur_ph),
    .win(vwin), .contest(vcontest)
  );

  assign on_ph    = (cur_ph == phase);
  assign emit     = in_valid && ((locked && on_ph) || vwin);
  assign miss_hit = in_valid && hit && locked && !on_ph;
  assign keep_hit = in_valid && hit && locked && on_ph;
  assign drop     = miss_hit && (miss == MW'(MISS_TH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_out   <= '0;
      sym_valid <= 1'b0;
      comma_det <= 1'b0;
      locked    <= 1'b0;
      phase     <= '0;
      miss      <= '0;
    end else begin
      sym_valid <= emit;
      comma_det <= emit && hit;
      if (emit) sym_out <= window;
      if (vwin) begin
        locked <= 1'b1;
        phase  <= cur_ph;
        miss   <= '0;
      end else if (drop) begin
        locked <= 1'b0;
        miss   <= '0;
      end else if (miss_hit) begin
        miss <= miss + 1'b1;
      end else if (keep_hit) begin
        miss <= '0;
      end
    end
  end
endmodule

// File: rtl/comma_vote_align_chk.sv
module comma_vote_align_chk
  import cva_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [SYM_W-1:0] sym_out,
  input logic             sym_valid,
  input logic             comma_det,
  input logic             locked,
  input logic [PH_W-1:0]  phase
);
  a_r6_strobe_needs_lock: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> locked);
  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> !sym_valid);
  a_r7_comma_is_k285: assert property (@(posedge clk) disable iff (rst)
    comma_det |-> (sym_valid && (sym_out == K285_RDN || sym_out == K285_RDP)));
  a_r4_lock_on_comma: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> comma_det);
  a_r9_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !sym_valid);
  a_r10_phase_held: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> $stable(phase));
  a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
    phase < PH_W'(SYM_W));
endmodule

bind comma_vote_align comma_vote_align_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .sym_out(sym_out),
  .sym_valid(sym_valid), .comma_det(comma_det), .locked(locked), .phase(phase)
);

// File: tb/tb_comma_vote_align.sv
module tb_comma_vote_align;
  localparam logic [9:0] KN = 10'b0011111010;
  localparam logic [9:0] KP = 10'b1100000101;
  localparam int VTH = 2;
  localparam int MTH = 3;

  logic clk = 1'b0;
  logic rst, in_valid, in_bit;
  logic [9:0] sym_out;
  logic sym_valid, comma_det, locked;
  logic [3:0] phase;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  comma_vote_align #(.VOTE_TH(VTH), .MISS_TH(MTH)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .sym_out(sym_out), .sym_valid(sym_valid), .comma_det(comma_det),
    .locked(locked), .phase(phase)
  );

  // reference model state
  logic [9:0] m_hist;
  int m_cnt, m_ph, m_miss;
  int m_votes [10];
  bit m_lock;
  bit e_sv, e_cd;
  logic [9:0] e_sym;

  function automatic bit is_k(logic [9:0] w);
    return (w == KN) || (w == KP);
  endfunction

  task automatic m_reset();
    m_hist = '0; m_cnt = 0; m_ph = 0; m_miss = 0; m_lock = 0;
    foreach (m_votes[i]) m_votes[i] = 0;
    e_sv = 0; e_cd = 0; e_sym = '0;
  endtask

  task automatic m_step(bit b, bit v);
    logic [9:0] w;
    int others;
    e_sv = 0; e_cd = 0;
    if (!v) return;
    w = {m_hist[8:0], b};
    if (!m_lock) begin
      if (is_k(w)) begin
        if (m_votes[m_cnt] + 1 >= VTH) begin
          others = 0;
          foreach (m_votes[i]) if (i != m_cnt) others += m_votes[i];
          if (others == 0) begin
            m_lock = 1; m_ph = m_cnt; m_miss = 0;
            e_sv = 1; e_cd = 1; e_sym = w;
          end
          foreach (m_votes[i]) m_votes[i] = 0;
        end else m_votes[m_cnt]++;
      end
    end else if (m_cnt == m_ph) begin
      e_sv = 1; e_sym = w; e_cd = is_k(w);
      if (is_k(w)) m_miss = 0;
    end else if (is_k(w)) begin
      if (m_miss + 1 >= MTH) begin
        m_lock = 0; m_miss = 0;
        foreach (m_votes[i]) m_votes[i] = 0;
      end else m_miss++;
    end
    m_hist = w;
    m_cnt = (m_cnt == 9) ? 0 : m_cnt + 1;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare every output against the model, at a falling edge
  task automatic compare();
    check(sym_valid == e_sv, "R6,R9 sym_valid", int'(sym_valid), int'(e_sv));
    check(comma_det == e_cd, "R7 comma_det", int'(comma_det), int'(e_cd));
    check(locked == m_lock, "R4,R5,R8 locked", int'(locked), int'(m_lock));
    check(int'(phase) == m_ph, "R2,R10 phase", int'(phase), m_ph);
    if (e_sv) check(sym_out == e_sym, "R6 sym_out", int'(sym_out), int'(e_sym));
  endtask

  task automatic send_bit(bit b, bit v);
    @(negedge clk);
    compare();
    in_valid = v; in_bit = b;
    m_step(b, v);
  endtask

  task automatic send_word(logic [9:0] w, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i], 1'b1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; in_bit = 0;
    repeat (3) @(negedge clk);
    check(locked == 0 && sym_valid == 0 && comma_det == 0 && phase == 0,
          "R1 reset outputs", int'(locked), 0);
    m_reset();
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [9:0] codes [6];
    int unused_seed;
    codes[0] = 10'b1010101010; codes[1] = 10'b0101010101;
    codes[2] = 10'b1011101000; codes[3] = 10'b1001110100;
    codes[4] = 10'b0110001011; codes[5] = 10'b1100010110;
    unused_seed = $urandom(32'd2024);
    m_reset();
    do_reset();
    idle(1);

    // R3: fragments and near-commas must never lock
    for (int i = 0; i < 20; i++) begin
      send_word(10'b1011101000, 10);
      send_word(10'b0011110010, 10);
      send_word(10'b0011111001, 10);
      send_word(10'b0011111000, 10);
    end
    idle(1);
    check(locked == 0, "R3 no lock on false commas", int'(locked), 0);

    // R2,R4: positive polarity lock at phase 2
    do_reset();
    send_word(10'b0000000101, 3);
    send_word(KP, 10);
    send_word(10'b1010101010, 10);
    send_word(KP, 10);
    idle(1);
    check(locked == 1, "R4 lock after two votes", int'(locked), 1);
    check(phase == 2, "R2 lock phase", int'(phase), 2);
    // R9: gaps between valid bits while locked
    for (int i = 0; i < 40; i++) send_bit(1'(i % 3), 1'(i % 2));
    check(phase == 2, "R10 phase held", int'(phase), 2);

    // R5: contested vote clears all counters
    do_reset();
    send_word(KN, 10);                  // phase 9
    send_word(10'b0000000010, 3);
    send_word(KN, 10);                  // phase 2
    send_word(10'b0001010101, 7);
    send_word(KN, 10);                  // phase 9 again, contested
    idle(1);
    check(locked == 0, "R5 contested vote", int'(locked), 0);
    send_word(10'b1010101010, 10);
    send_word(KN, 10);
    idle(1);
    check(locked == 0, "R5 votes were cleared", int'(locked), 0);
    send_word(KN, 10);
    idle(1);
    check(locked == 1 && phase == 9, "R4 relock after contest", int'(phase), 9);

    // R8: misses, in-phase clear, then drop
    send_bit(1'b0, 1'b1);
    send_word(KN, 10); send_word(KN, 10);   // two misses at phase 0
    send_word(10'b0101010101, 9);
    send_word(KN, 10);                      // in phase 9, clears misses
    send_bit(1'b0, 1'b1);
    send_word(KN, 10); send_word(KN, 10);
    idle(1);
    check(locked == 1, "R8 in-phase comma cleared misses", int'(locked), 1);
    send_word(KN, 10);
    idle(1);
    check(locked == 0, "R8 drop after three misses", int'(locked), 0);

    // random traffic with slips and gaps
    do_reset();
    for (int s = 0; s < 900; s++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 20)      send_word(($urandom_range(0, 1) != 0) ? KP : KN, 10);
      else if (r < 23) send_bit(1'($urandom_range(0, 1)), 1'b1);
      else if (r < 27) idle(int'($urandom_range(1, 3)));
      else             send_word(codes[$urandom_range(0, 5)], 10);
    end
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule